// File: doc/BRIEF.md
# Two-Stage Translation Entry Combiner

This block takes a first-stage translation entry and the matching second-stage entry and folds them into one entry that a first-stage translation cache can store directly. Memory type, cacheability at two levels, the two shareability flags, the non-cacheable and execute-never bits, and the page size, page number and frame number are each settled by a fixed rule rather than copied from one stage.

A pair of entries arrives with the original virtual address and a fault flag from the second-stage lookup under a valid/ready handshake. The result is registered and presented under a second valid/ready handshake. When the second stage faulted, the result is a fault record carrying the original virtual address instead of an entry. Page sizes are carried as log2 of the byte size (12, 21, 30 and so on), so all scaling reduces to shifts.

Top module: `xlat_merge`

## Requirements
- R1: The output execute-never bit is the OR of both stages' execute-never bits, and the output non-cacheable bit is the OR of both stages' non-cacheable bits.
- R2: Memory type uses the code 0 = normal, 1 = device, 2 = strongly ordered. The output is 2 if either stage is 2, otherwise 1 if either stage is 1, otherwise 0.
- R3: For normal memory, the inner and outer cacheability codes (0 = non-cacheable, 2 = write-through, 3 = write-back) are each resolved on their own: 0 if either stage gives 0, else 2 if either stage gives 2, else 3. For device or strongly-ordered memory, both output codes are 0.
- R4: The inner-shareable and outer-shareable outputs are each the OR of both stages' flags. Both are forced to 1 when the resolved inner and outer codes are both 0, and both are forced to 1 when the resolved memory type is not normal.
- R5: The output page size is the smaller of the two sizes. When the first-stage size is larger, the output page number is the virtual address shifted right by the second-stage size, and the output frame number is the second-stage frame number.
- R6: When the first-stage size is smaller by d, the output frame number is the second-stage frame number shifted left by d, with its low d bits taken from the low d bits of the first-stage frame number, and the output page number is the first-stage page number. When the sizes are equal, the output frame number is the second-stage frame number and the page number is the first-stage page number.
- R7: When the second-stage fault flag is set on an accepted pair, the result has the fault output at 1, the fault address output equal to the virtual address, and all entry outputs at 0.
- R8: The input ready output is 1 when no result is held or the output ready input is 1. An accepted pair is presented with output valid at 1 from the next clock edge, and the result stays unchanged while output ready is 0.
- R9: A synchronous active-high reset sets the output valid and fault outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pair valid |
| in_ready | output | 1 | Input pair accepted when high with in_valid |
| s2_fault | input | 1 | Second-stage lookup fault |
| va | input | VA_W | Original virtual address |
| s1_size | input | SZ_W | First-stage page size, log2 bytes |
| s1_vpn | input | VA_W | First-stage virtual page number |
| s1_pfn | input | PA_W | First-stage frame number (intermediate page) |
| s1_mtype | input | 2 | First-stage memory type |
| s1_inner | input | 2 | First-stage inner cacheability |
| s1_outer | input | 2 | First-stage outer cacheability |
| s1_ish | input | 1 | First-stage inner shareable |
| s1_osh | input | 1 | First-stage outer shareable |
| s1_nc | input | 1 | First-stage non-cacheable |
| s1_xn | input | 1 | First-stage execute-never |
| s2_size | input | SZ_W | Second-stage page size, log2 bytes |
| s2_pfn | input | PA_W | Second-stage frame number |
| s2_mtype | input | 2 | Second-stage memory type |
| s2_inner | input | 2 | Second-stage inner cacheability |
| s2_outer | input | 2 | Second-stage outer cacheability |
| s2_ish | input | 1 | Second-stage inner shareable |
| s2_osh | input | 1 | Second-stage outer shareable |
| s2_nc | input | 1 | Second-stage non-cacheable |
| s2_xn | input | 1 | Second-stage execute-never |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumed when high with out_valid |
| out_fault | output | 1 | Result is a fault record |
| out_fault_va | output | VA_W | Virtual address of a faulting pair |
| out_size | output | SZ_W | Combined page size |
| out_vpn | output | VA_W | Combined page number |
| out_pfn | output | PA_W | Combined frame number |
| out_mtype | output | 2 | Combined memory type |
| out_inner | output | 2 | Combined inner cacheability |
| out_outer | output | 2 | Combined outer cacheability |
| out_ish | output | 1 | Combined inner shareable |
| out_osh | output | 1 | Combined outer shareable |
| out_nc | output | 1 | Combined non-cacheable |
| out_xn | output | 1 | Combined execute-never |

## Verification
The bench drives the three size relations on purpose: a large first-stage page over small second-stage pages, where a design that kept the first-stage page number would map a whole large region with one small frame; and a small page inside a large second-stage page, where forgetting the low intermediate bits would send every small page to the base of the large one. It mixes cacheability codes so that a write-through on one side and a write-back on the other, or a non-cacheable at one level only, show up as a wrong code or a missing shareability force. Device and strongly-ordered pairs check precedence and the forced flags, and faulting pairs and a stalled output check that the fault address and a held result survive.

// File: rtl/xlat_merge_pkg.sv
package xlat_merge_pkg;

  typedef enum logic [1:0] {
    MT_NORMAL = 2'd0,
    MT_DEVICE = 2'd1,
    MT_STRONG = 2'd2
  } mtype_e;

  localparam logic [1:0] CA_NONE = 2'd0;
  localparam logic [1:0] CA_WT   = 2'd2;
  localparam logic [1:0] CA_WB   = 2'd3;

  localparam int unsigned NUM_CLEVELS = 2;

endpackage

// File: rtl/xlat_cache_level.sv
module xlat_cache_level
  import xlat_merge_pkg::*;
(
  input  logic [1:0] code_a,
  input  logic [1:0] code_b,
  output logic [1:0] code_y
);
  always_comb begin
    if (code_a == CA_NONE || code_b == CA_NONE)
      code_y = CA_NONE;
    else if (code_a == CA_WT || code_b == CA_WT)
      code_y = CA_WT;
    else
      code_y = CA_WB;
  end
endmodule

// File: rtl/xlat_attr_merge.sv
module xlat_attr_merge
  import xlat_merge_pkg::*;
(
  input  logic [1:0] a_mtype,
  input  logic [1:0] a_inner,
  input  logic [1:0] a_outer,
  input  logic       a_ish,
  input  logic       a_osh,
  input  logic       a_nc,
  input  logic       a_xn,
  input  logic [1:0] b_mtype,
  input  logic [1:0] b_inner,
  input  logic [1:0] b_outer,
  input  logic       b_ish,
  input  logic       b_osh,
  input  logic       b_nc,
  input  logic       b_xn,
  output logic [1:0] y_mtype,
  output logic [1:0] y_inner,
  output logic [1:0] y_outer,
  output logic       y_ish,
  output logic       y_osh,
  output logic       y_nc,
  output logic       y_xn
);
  logic [1:0] lvl_a [NUM_CLEVELS];
  logic [1:0] lvl_b [NUM_CLEVELS];
  logic [1:0] lvl_y [NUM_CLEVELS];
  logic       is_normal;
  logic       all_nc;

  assign lvl_a[0] = a_inner;
  assign lvl_a[1] = a_outer;
  assign lvl_b[0] = b_inner;
  assign lvl_b[1] = b_outer;

  for (genvar g = 0; g < NUM_CLEVELS; g++) begin : g_lvl
    xlat_cache_level u_lvl (
      .code_a (lvl_a[g]),
      .code_b (lvl_b[g]),
      .code_y (lvl_y[g])
    );
  end

  always_comb begin
    if (a_mtype == MT_STRONG || b_mtype == MT_STRONG)
      y_mtype = MT_STRONG;
    else if (a_mtype == MT_DEVICE || b_mtype == MT_DEVICE)
      y_mtype = MT_DEVICE;
    else
      y_mtype = MT_NORMAL;
  end

  assign is_normal = (y_mtype == MT_NORMAL);
  assign y_inner   = is_normal ? lvl_y[0] : CA_NONE;
  assign y_outer   = is_normal ? lvl_y[1] : CA_NONE;
  assign all_nc    = (y_inner == CA_NONE) && (y_outer == CA_NONE);
  assign y_ish     = a_ish | b_ish | all_nc | ~is_normal;
  assign y_osh     = a_osh | b_osh | all_nc | ~is_normal;
  assign y_nc      = a_nc | b_nc;
  assign y_xn      = a_xn | b_xn;
endmodule

// File: rtl/xlat_page_merge.sv
module xlat_page_merge #(
  parameter int VA_W = 48,
  parameter int PA_W = 40,
  parameter int SZ_W = 6
) (
  input  logic [VA_W-1:0] va,
  input  logic [SZ_W-1:0] a_size,
  input  logic [VA_W-1:0] a_vpn,
  input  logic [PA_W-1:0] a_pfn,
  input  logic [SZ_W-1:0] b_size,
  input  logic [PA_W-1:0] b_pfn,
  output logic [SZ_W-1:0] y_size,
  output logic [VA_W-1:0] y_vpn,
  output logic [PA_W-1:0] y_pfn
);
  localparam logic [PA_W-1:0] ALL_ONES = {PA_W{1'b1}};

  logic [SZ_W-1:0] diff;
  logic [PA_W-1:0] low_mask;

  assign diff     = b_size - a_size;
  assign low_mask = ~(ALL_ONES << diff);

  always_comb begin
    if (a_size > b_size) begin
      y_size = b_size;
      y_vpn  = va >> b_size;
      y_pfn  = b_pfn;
    end else if (a_size < b_size) begin
      y_size = a_size;
      y_vpn  = a_vpn;
      y_pfn  = (b_pfn << diff) | (a_pfn & low_mask);
    end else begin
      y_size = a_size;
      y_vpn  = a_vpn;
      y_pfn  = b_pfn;
    end
  end
endmodule

// File: rtl/xlat_merge.sv
module xlat_merge
  import xlat_merge_pkg::*;
#(
  parameter int VA_W = 48,
  parameter int PA_W = 40,
  parameter int SZ_W = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            s2_fault,
  input  logic [VA_W-1:0] va,
  input  logic [SZ_W-1:0] s1_size,
  input  logic [VA_W-1:0] s1_vpn,
  input  logic [PA_W-1:0] s1_pfn,
  input  logic [1:0]      s1_mtype,
  input  logic [1:0]      s1_inner,
  input  logic [1:0]      s1_outer,
  input  logic            s1_ish,
  input  logic            s1_osh,
  input  logic            s1_nc,
  input  logic            s1_xn,
  input  logic [SZ_W-1:0] s2_size,
  input  logic [PA_W-1:0] s2_pfn,
  input  logic [1:0]      s2_mtype,
  input  logic [1:0]      s2_inner,
  input  logic [1:0]      s2_outer,
  input  logic            s2_ish,
  input  logic            s2_osh,
  input  logic            s2_nc,
  input  logic            s2_xn,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_fault,
  output logic [VA_W-1:0] out_fault_va,
  output logic [SZ_W-1:0] out_size,
  output logic [VA_W-1:0] out_vpn,
  output logic [PA_W-1:0] out_pfn,
  output logic [1:0]      out_mtype,
  output logic [1:0]      out_inner,
  output logic [1:0]      out_outer,
  output logic            out_ish,
  output logic            out_osh,
  output logic            out_nc,
  output logic            out_xn
);
  logic [1:0]      m_mtype, m_inner, m_outer;
  logic            m_ish, m_osh, m_nc, m_xn;
  logic [SZ_W-1:0] m_size;
  logic [VA_W-1:0] m_vpn;
  logic [PA_W-1:0] m_pfn;
  logic            take;

  xlat_attr_merge u_attr (
    .a_mtype (s1_mtype), .a_inner (s1_inner), .a_outer (s1_outer),
    .a_ish   (s1_ish),   .a_osh   (s1_osh),   .a_nc    (s1_nc),
    .a_xn    (s1_xn),
    .b_mtype (s2_mtype), .b_inner (s2_inner), .b_outer (s2_outer),
    .b_ish   (s2_ish),   .b_osh   (s2_osh),   .b_nc    (s2_nc),
    .b_xn    (s2_xn),
    .y_mtype (m_mtype),  .y_inner (m_inner),  .y_outer (m_outer),
    .y_ish   (m_ish),    .y_osh   (m_osh),    .y_nc    (m_nc),
    .y_xn    (m_xn)
  );

  xlat_page_merge #(.VA_W(VA_W), .PA_W(PA_W), .SZ_W(SZ_W)) u_page (
    .va     (va),
    .a_size (s1_size), .a_vpn (s1_vpn), .a_pfn (s1_pfn),
    .b_size (s2_size), .b_pfn (s2_pfn),
    .y_size (m_size),  .y_vpn (m_vpn),  .y_pfn (m_pfn)
  );

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_fault <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_fault <= s2_fault;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      out_fault_va <= s2_fault ? va : '0;
      if (s2_fault) begin
        out_size  <= '0;
        out_vpn   <= '0;
        out_pfn   <= '0;
        out_mtype <= '0;
        out_inner <= '0;
        out_outer <= '0;
        out_ish   <= 1'b0;
        out_osh   <= 1'b0;
        out_nc    <= 1'b0;
        out_xn    <= 1'b0;
      end else begin
        out_size  <= m_size;
        out_vpn   <= m_vpn;
        out_pfn   <= m_pfn;
        out_mtype <= m_mtype;
        out_inner <= m_inner;
        out_outer <= m_outer;
        out_ish   <= m_ish;
        out_osh   <= m_osh;
        out_nc    <= m_nc;
        out_xn    <= m_xn;
      end
    end
  end
endmodule

// File: rtl/xlat_merge_chk.sv
module xlat_merge_chk #(
  parameter int VA_W = 48,
  parameter int PA_W = 40,
  parameter int SZ_W = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic            s2_fault,
  input logic [VA_W-1:0] va,
  input logic [SZ_W-1:0] s1_size,
  input logic [SZ_W-1:0] s2_size,
  input logic            s1_xn,
  input logic            s2_xn,
  input logic            out_valid,
  input logic            out_ready,
  input logic            out_fault,
  input logic [VA_W-1:0] out_fault_va,
  input logic [SZ_W-1:0] out_size,
  input logic [PA_W-1:0] out_pfn,
  input logic [1:0]      out_mtype,
  input logic [1:0]      out_inner,
  input logic [1:0]      out_outer,
  input logic            out_ish,
  input logic            out_osh,
  input logic            out_xn
);
  // R1
  p_xn_or_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !s2_fault) |=> (out_xn == ($past(s1_xn) | $past(s2_xn))));

  // R3
  p_code_legal_r3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_fault) |-> (out_inner != 2'd1 && out_outer != 2'd1));

  // R4
  p_share_dev_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_fault && out_mtype != 2'd0) |-> (out_ish && out_osh));

  // R4
  p_share_nc_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_fault && out_inner == 2'd0 && out_outer == 2'd0) |-> (out_ish && out_osh));

  // R5
  p_size_min_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !s2_fault) |=>
      (out_size == (($past(s1_size) < $past(s2_size)) ? $past(s1_size) : $past(s2_size))));

  // R7
  p_fault_va_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && s2_fault) |=> (out_valid && out_fault && out_fault_va == $past(va)));

  // R8
  p_stall_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R8
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pfn) && $stable(out_fault)));
endmodule

bind xlat_merge xlat_merge_chk #(.VA_W(VA_W), .PA_W(PA_W), .SZ_W(SZ_W)) i_chk (
  .clk (clk), .rst (rst), .in_valid (in_valid), .in_ready (in_ready),
  .s2_fault (s2_fault), .va (va), .s1_size (s1_size), .s2_size (s2_size),
  .s1_xn (s1_xn), .s2_xn (s2_xn), .out_valid (out_valid), .out_ready (out_ready),
  .out_fault (out_fault), .out_fault_va (out_fault_va), .out_size (out_size),
  .out_pfn (out_pfn), .out_mtype (out_mtype), .out_inner (out_inner),
  .out_outer (out_outer), .out_ish (out_ish), .out_osh (out_osh), .out_xn (out_xn)
);

// File: tb/test_xlat_merge.sv
module test_xlat_merge;
  localparam int VA_W = 48;
  localparam int PA_W = 40;
  localparam int SZ_W = 6;

  logic clk = 1'b0;
  logic rst;
  always #4 clk = ~clk;

  logic in_valid, in_ready, s2_fault, out_valid, out_ready, out_fault;
  logic [VA_W-1:0] va, s1_vpn, out_fault_va, out_vpn;
  logic [SZ_W-1:0] s1_size, s2_size, out_size;
  logic [PA_W-1:0] s1_pfn, s2_pfn, out_pfn;
  logic [1:0] s1_mtype, s1_inner, s1_outer, s2_mtype, s2_inner, s2_outer;
  logic [1:0] out_mtype, out_inner, out_outer;
  logic s1_ish, s1_osh, s1_nc, s1_xn, s2_ish, s2_osh, s2_nc, s2_xn;
  logic out_ish, out_osh, out_nc, out_xn;

  xlat_merge #(.VA_W(VA_W), .PA_W(PA_W), .SZ_W(SZ_W)) i_xlat_merge (.*);

  int checks = 0;
  int errors = 0;

  task automatic chk(string tag, logic [159:0] act, logic [159:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] cres(logic [1:0] a, logic [1:0] b);
    if (a == 2'd0 || b == 2'd0) return 2'd0;
    if (a == 2'd2 || b == 2'd2) return 2'd2;
    return 2'd3;
  endfunction

  function automatic logic [9:0] exp_attr();
    logic [1:0] mt, ci, co;
    logic sh, osh;
    if (s1_mtype == 2'd2 || s2_mtype == 2'd2) mt = 2'd2;
    else if (s1_mtype == 2'd1 || s2_mtype == 2'd1) mt = 2'd1;
    else mt = 2'd0;
    ci = (mt == 2'd0) ? cres(s1_inner, s2_inner) : 2'd0;
    co = (mt == 2'd0) ? cres(s1_outer, s2_outer) : 2'd0;
    sh  = s1_ish | s2_ish;
    osh = s1_osh | s2_osh;
    if (mt != 2'd0 || (ci == 2'd0 && co == 2'd0)) begin
      sh = 1'b1;
      osh = 1'b1;
    end
    return {mt, ci, co, sh, osh, s1_nc | s2_nc, s1_xn | s2_xn};
  endfunction

  function automatic logic [93:0] exp_page();
    logic [SZ_W-1:0] d;
    logic [PA_W-1:0] pf;
    if (s1_size > s2_size) return {s2_size, va >> s2_size, s2_pfn};
    if (s1_size == s2_size) return {s1_size, s1_vpn, s2_pfn};
    d  = s2_size - s1_size;
    pf = s2_pfn << d;
    for (int i = 0; i < PA_W; i++)
      if (i < int'(d)) pf[i] = s1_pfn[i];
    return {s1_size, s1_vpn, pf};
  endfunction

  function automatic logic [9:0] act_attr();
    return {out_mtype, out_inner, out_outer, out_ish, out_osh, out_nc, out_xn};
  endfunction

  task automatic go(string tag);
    @(negedge clk);
    in_valid = 1'b1;
    chk({tag, " R8 in_ready"}, 160'(in_ready), 160'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R8 out_valid"}, 160'(out_valid), 160'd1);
    if (s2_fault) begin
      chk({tag, " R7 fault va"}, {out_fault, out_fault_va}, {1'b1, va});
      chk({tag, " R7 entry zero"}, {act_attr(), out_size, out_vpn, out_pfn}, '0);
    end else begin
      chk({tag, " R1 R2 R3 R4 attrs"}, 160'(act_attr()), 160'(exp_attr()));
      chk({tag, (s1_size > s2_size) ? " R5 page" : " R6 page"},
          {out_size, out_vpn, out_pfn}, exp_page());
      chk({tag, " R7 no fault"}, 160'(out_fault), 160'd0);
    end
  endtask

  task automatic set_pages(int a, int b, logic [VA_W-1:0] v);
    s1_size = SZ_W'(a);
    s2_size = SZ_W'(b);
    va      = v;
    s1_vpn  = v >> a;
    s1_pfn  = PA_W'({$urandom, $urandom});
    s2_pfn  = PA_W'($urandom);
  endtask

  task automatic set_attr(logic [1:0] m1, logic [1:0] i1, logic [1:0] o1,
                          logic [1:0] m2, logic [1:0] i2, logic [1:0] o2, logic [7:0] bits);
    s1_mtype = m1; s1_inner = i1; s1_outer = o1;
    s2_mtype = m2; s2_inner = i2; s2_outer = o2;
    {s1_ish, s1_osh, s1_nc, s1_xn, s2_ish, s2_osh, s2_nc, s2_xn} = bits;
  endtask

  function automatic int pick_size(int r);
    case (r % 3)
      0: return 12;
      1: return 21;
      default: return 30;
    endcase
  endfunction

  function automatic logic [1:0] pick_code(int r);
    case (r % 4)
      0: return 2'd0;
      1: return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [PA_W-1:0] held;
    void'($urandom(32'd20240611));
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b1; s2_fault = 1'b0;
    set_pages(12, 12, 48'h0);
    set_attr(0, 3, 3, 0, 3, 3, 8'h00);
    repeat (3) @(negedge clk);
    chk("R9 reset valid/fault", {out_valid, out_fault}, 2'b00);
    rst = 1'b0;

    // R2 R4: strongly ordered wins, forced shareable
    set_attr(2, 3, 3, 1, 3, 3, 8'h00); set_pages(12, 12, 48'h1234_5678_9000); go("strong");
    // R2: device over normal, R3 codes forced to 0
    set_attr(0, 3, 3, 1, 2, 3, 8'h00); set_pages(21, 21, 48'h0abc_0020_0000); go("device");
    // R3: write-through vs write-back, R1 or bits
    set_attr(0, 2, 3, 0, 3, 3, 8'b0001_0010); go("wt_wb");
    // R3 R4: inner nc only, no forcing
    set_attr(0, 0, 3, 0, 3, 3, 8'h00); go("inner_nc");
    // R4: both levels nc forces shareable
    set_attr(0, 3, 0, 0, 0, 3, 8'h00); go("both_nc");
    // R5: first stage larger
    set_attr(0, 3, 3, 0, 3, 3, 8'b1000_0100);
    set_pages(30, 12, 48'h7fed_cba9_8765); go("s1_big");
    set_pages(21, 12, 48'h0000_1234_5abc); go("s1_big2");
    // R6: first stage smaller and equal
    set_pages(12, 30, 48'h0123_4567_8abc); go("s1_small");
    set_pages(12, 21, 48'hffff_ffff_f000); go("s1_small2");
    set_pages(30, 30, 48'h0040_0000_0000); go("equal");
    // R7: fault
    s2_fault = 1'b1; go("fault"); s2_fault = 1'b0;

    // R8: hold while out_ready low
    @(negedge clk);
    out_ready = 1'b0;
    set_pages(12, 21, 48'h0000_0765_4321);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    held = out_pfn;
    chk("R8 accepted under stall", 160'(out_valid), 160'd1);
    for (int k = 0; k < 3; k++) begin
      in_valid = 1'b1;
      @(negedge clk);
      chk("R8 hold valid/ready", {out_valid, in_ready}, 2'b10);
      chk("R8 hold data", 160'(out_pfn), 160'(held));
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    chk("R8 drained", 160'(out_valid), 160'd0);

    // random mix
    for (int n = 0; n < 400; n++) begin
      set_attr(2'($urandom % 3), pick_code(int'($urandom)), pick_code(int'($urandom)),
               2'($urandom % 3), pick_code(int'($urandom)), pick_code(int'($urandom)),
               8'($urandom));
      set_pages(pick_size(int'($urandom)), pick_size(int'($urandom)),
                VA_W'({$urandom, $urandom}));
      s2_fault = (($urandom % 8) == 0);
      go("random");
    end
    s2_fault = 1'b0;

    @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule